// File: doc/BRIEF.md
# Debug-Link Instruction Sequence Tracker

This block watches the byte stream of a two-wire program-and-debug link after a frame receiver has removed framing. It takes each accepted byte together with break events. The first byte of each transaction is taken as an instruction opcode. From the opcode fields the block works out how many operand and data items follow, how wide each one is, and whether each item is written by the host or returned by the device. The bytes of each item are gathered least significant byte first, and the finished item is presented on an output stream. The opcode fields are also latched for observers.

Direction and item boundaries are never read from the wire. They come only from the opcode and from a repeat count, which one instruction leaves behind for the next pointer-based transfer. The input and output are valid/ready streams. An assembled item stays on the output until it is taken. While an item is waiting, the input withholds `in_ready`, so back-pressure from the item consumer stalls the byte source and no byte is ever lost. A break pulse is a plain control input. It takes priority over any byte offered in the same cycle.

Top module: `dlt_insn_tracker`

## Requirements
- R1: The first byte accepted after reset, after a break or after a completed instruction is an opcode. In the cycle after it is accepted, `op_strobe` pulses for one cycle. From that cycle until the next opcode, the fields hold these values: `op_code` = byte bits 7:5, `op_addr_len` = bits 3:2 plus 1, `op_data_len` = bits 1:0 plus 1, `op_sel` = bits 3:0.
- R2: The items that follow depend on the opcode value, with A = address length and D = data length. Code 0 gives an A-byte write, then a D-byte read. Code 1 gives D-byte reads. Code 2 gives an A-byte write, then a D-byte write. Code 3 gives D-byte writes. Code 4 gives one 1-byte read. Code 5 gives one D-byte write, which is the repeat count. Code 6 gives one 1-byte write. Code 7 gives one 8-byte write. `item_len` reports each item's byte count.
- R3: `item_is_read` is 1 for device-returned items and 0 for host-written items. Within an instruction, every written item comes before any read item.
- R4: Item bytes are placed least significant byte first in `item_data`. Bytes beyond the fourth of an item are counted but not stored.
- R5: When a code-5 instruction completes, its item value (low 32 bits) becomes the repeat count N on `rep_count`. The next code-1 or code-3 instruction moves N+1 data items and clears the count to 0. Instructions with other codes leave the count unchanged.
- R6: A `brk` pulse abandons the current instruction and any partly gathered item, and clears the repeat count. The next accepted byte is then an opcode. While `brk` is high, `in_ready` is low.
- R7: `insn_done` pulses for one cycle, in the same cycle that the last item of an instruction first appears on the output.
- R8: While `item_valid` is high and `item_ready` is low, the item outputs hold steady and `in_ready` is low.
- R9: After reset, `item_valid`, `insn_done`, `op_strobe` and `busy` are 0, `rep_count` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte taken this cycle when high together with in_valid |
| in_data | input | 8 | Received byte |
| brk | input | 1 | Break event pulse |
| item_valid | output | 1 | Assembled item available |
| item_ready | input | 1 | Consumer takes the item |
| item_data | output | 32 | Item value, little-endian assembled |
| item_is_read | output | 1 | 1 for device-returned item |
| item_len | output | 4 | Item length in bytes |
| op_strobe | output | 1 | One-cycle pulse after an opcode byte is taken |
| op_code | output | 3 | Latched opcode field |
| op_addr_len | output | 3 | Latched address length in bytes |
| op_data_len | output | 3 | Latched data length in bytes |
| op_sel | output | 4 | Latched low nibble (pointer mode or control register) |
| busy | output | 1 | An instruction is in progress |
| insn_done | output | 1 | Last item of an instruction produced |
| rep_count | output | 32 | Pending repeat count |

## Verification
Every one of the 256 opcode byte values is driven once, each followed by computed payload bytes. This separates the eight item layouts and all address and data widths, including the 8-byte key, whose upper bytes are dropped. Repeat counts of 0 to 3 are loaded with one-byte and two-byte count items and then applied to pointer loads and stores. An instruction with an unrelated opcode is placed between the count and the transfer, to show that the count survives it. Breaks are sent in the middle of an instruction with a byte offered at the same time, which shows that partial items and the count are discarded. Part of the sweep is repeated while the consumer withholds `item_ready` two cycles in three, which separates correct back-pressure from dropped or altered items.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

  localparam int LEN_W = 4;

  typedef enum logic [2:0] {
    OPC_LOAD_DIR   = 3'd0,
    OPC_LOAD_PTR   = 3'd1,
    OPC_STORE_DIR  = 3'd2,
    OPC_STORE_PTR  = 3'd3,
    OPC_LOAD_CREG  = 3'd4,
    OPC_REPEAT     = 3'd5,
    OPC_STORE_CREG = 3'd6,
    OPC_KEY        = 3'd7
  } dl_op_e;

  typedef enum logic [1:0] {
    PH_OPC = 2'd0,
    PH_WA  = 2'd1,
    PH_WB  = 2'd2,
    PH_RD  = 2'd3
  } dl_phase_e;

  // Item plan for one instruction: an optional single leading write,
  // a write group and a read group, each group optionally repeated.
  typedef struct packed {
    dl_op_e           op;
    logic [LEN_W-1:0] wa_len;
    logic [LEN_W-1:0] wb_len;
    logic             wb_rep;
    logic [LEN_W-1:0] rd_len;
    logic             rd_rep;
  } dl_plan_t;

endpackage

// File: rtl/dlt_opdecode.sv
module dlt_opdecode
  import dlt_pkg::*;
#(
  parameter int KEY_LEN = 8
) (
  input  logic [7:0] opc_byte,
  output dl_plan_t   plan,
  output logic [2:0] addr_len,
  output logic [2:0] data_len
);

  localparam logic [LEN_W-1:0] ONE_B = LEN_W'(1);
  localparam logic [LEN_W-1:0] KEY_B = LEN_W'(KEY_LEN);

  logic [LEN_W-1:0] a_l;
  logic [LEN_W-1:0] d_l;

  assign a_l      = LEN_W'(opc_byte[3:2]) + ONE_B;
  assign d_l      = LEN_W'(opc_byte[1:0]) + ONE_B;
  assign addr_len = {1'b0, opc_byte[3:2]} + 3'd1;
  assign data_len = {1'b0, opc_byte[1:0]} + 3'd1;

  always_comb begin
    plan    = '0;
    plan.op = dl_op_e'(opc_byte[7:5]);
    unique case (plan.op)
      OPC_LOAD_DIR: begin
        plan.wa_len = a_l;
        plan.rd_len = d_l;
      end
      OPC_LOAD_PTR: begin
        plan.rd_len = d_l;
        plan.rd_rep = 1'b1;
      end
      OPC_STORE_DIR: begin
        plan.wa_len = a_l;
        plan.wb_len = d_l;
      end
      OPC_STORE_PTR: begin
        plan.wb_len = d_l;
        plan.wb_rep = 1'b1;
      end
      OPC_LOAD_CREG:  plan.rd_len = ONE_B;
      OPC_REPEAT:     plan.wb_len = d_l;
      OPC_STORE_CREG: plan.wb_len = ONE_B;
      OPC_KEY:        plan.wb_len = KEY_B;
      default:        plan.rd_len = ONE_B;
    endcase
  end

  // R2: every instruction carries at least one item
  always_comb begin
    a_r2_has_items: assert ((plan.wa_len | plan.wb_len | plan.rd_len) != '0)
      else $error("opcode plan has no items");
  end

endmodule

// File: rtl/dlt_item_asm.sv
module dlt_item_asm
  import dlt_pkg::*;
#(
  parameter int ITEM_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [7:0]        byte_in,
  input  logic [LEN_W-1:0]  len,
  output logic              last,
  output logic [ITEM_W-1:0] value
);

  localparam int ITEM_BYTES = ITEM_W / 8;

  logic [LEN_W-1:0]  idx;
  logic [ITEM_W-1:0] acc;

  assign last = (idx == len - LEN_W'(1));

  // One lane per stored byte; the lane at the current index takes the
  // incoming byte, others keep what was gathered so far.
  for (genvar g = 0; g < ITEM_BYTES; g++) begin : g_lane
    assign value[8*g +: 8] = (en && idx == LEN_W'(g)) ? byte_in : acc[8*g +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      idx <= '0;
      acc <= '0;
    end else if (en) begin
      if (last) begin
        idx <= '0;
        acc <= '0;
      end else begin
        idx <= idx + LEN_W'(1);
        acc <= value;
      end
    end
  end

  // R4: byte position never runs past the item length
  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (len != '0 && idx < len))
    else $error("item byte index beyond length");

endmodule

// File: rtl/dlt_seq.sv
module dlt_seq
  import dlt_pkg::*;
#(
  parameter int ITEM_W = 32,
  parameter int REP_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk,
  input  logic              byte_en,
  input  dl_plan_t          plan_in,
  input  logic              item_last,
  input  logic [ITEM_W-1:0] item_value,
  output logic              asm_en,
  output logic [LEN_W-1:0]  cur_len,
  output logic              item_fire,
  output logic              item_rd,
  output logic              opc_take,
  output logic              done,
  output logic              busy,
  output logic [REP_W-1:0]  rep_count
);

  localparam int CNT_W = REP_W + 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  dl_phase_e        phase;
  dl_plan_t         plan_q;
  logic [CNT_W-1:0] rem;
  logic [REP_W-1:0] rep_q;
  logic             done_q;
  logic             take_rep;

  function automatic dl_phase_e first_phase(input dl_plan_t p);
    if (p.wa_len != '0)      return PH_WA;
    else if (p.wb_len != '0) return PH_WB;
    else                     return PH_RD;
  endfunction

  assign opc_take  = byte_en && (phase == PH_OPC);
  assign asm_en    = byte_en && (phase != PH_OPC);
  assign item_fire = asm_en && item_last;
  assign item_rd   = (phase == PH_RD);
  assign take_rep  = plan_in.wb_rep || plan_in.rd_rep;
  assign done      = done_q;
  assign busy      = (phase != PH_OPC);
  assign rep_count = rep_q;

  always_comb begin
    unique case (phase)
      PH_WA:   cur_len = plan_q.wa_len;
      PH_WB:   cur_len = plan_q.wb_len;
      PH_RD:   cur_len = plan_q.rd_len;
      default: cur_len = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_OPC;
      plan_q <= '0;
      rem    <= '0;
      rep_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (brk) begin
        phase <= PH_OPC;
        rem   <= '0;
        rep_q <= '0;
      end else if (opc_take) begin
        plan_q <= plan_in;
        phase  <= first_phase(plan_in);
        if (take_rep) begin
          rem   <= {1'b0, rep_q} + CNT_ONE;
          rep_q <= '0;
        end else begin
          rem <= CNT_ONE;
        end
      end else if (item_fire) begin
        if (phase == PH_WA) begin
          phase <= (plan_q.wb_len != '0) ? PH_WB : PH_RD;
          rem   <= CNT_ONE;
        end else if (rem > CNT_ONE) begin
          rem <= rem - CNT_ONE;
        end else if (phase == PH_WB && plan_q.rd_len != '0) begin
          phase <= PH_RD;
          rem   <= CNT_ONE;
        end else begin
          phase  <= PH_OPC;
          done_q <= 1'b1;
          if (plan_q.op == OPC_REPEAT) rep_q <= REP_W'(item_value);
        end
      end
    end
  end

  // R6: a break leaves no instruction open and no pending count
  a_r6_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> (phase == PH_OPC && rep_q == '0))
    else $error("break did not clear sequencer");

  // R5: pointer transfers consume the count
  a_r5_count_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_take && take_rep) |=> (rep_q == '0))
    else $error("repeat count not consumed");

  // R5: other opcodes leave the count alone
  a_r5_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_take && !take_rep) |=> $stable(rep_q))
    else $error("repeat count changed by unrelated opcode");

  // R3: once reads start, no write group follows inside the instruction
  a_r3_reads_last: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RD && !brk) |=> (phase == PH_RD || phase == PH_OPC))
    else $error("write phase after read phase");

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q)
    else $error("done pulse longer than one cycle");

endmodule

// File: rtl/dlt_insn_tracker.sv
module dlt_insn_tracker
  import dlt_pkg::*;
#(
  parameter int ITEM_W  = 32,
  parameter int REP_W   = 32,
  parameter int KEY_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              brk,
  output logic              item_valid,
  input  logic              item_ready,
  output logic [ITEM_W-1:0] item_data,
  output logic              item_is_read,
  output logic [LEN_W-1:0]  item_len,
  output logic              op_strobe,
  output logic [2:0]        op_code,
  output logic [2:0]        op_addr_len,
  output logic [2:0]        op_data_len,
  output logic [3:0]        op_sel,
  output logic              busy,
  output logic              insn_done,
  output logic [REP_W-1:0]  rep_count
);

  dl_plan_t          plan;
  logic [2:0]        dec_alen;
  logic [2:0]        dec_dlen;
  logic              byte_en;
  logic              asm_en;
  logic              item_last;
  logic [ITEM_W-1:0] item_value;
  logic [LEN_W-1:0]  cur_len;
  logic              item_fire;
  logic              item_rd;
  logic              opc_take;

  assign in_ready = !brk && (!item_valid || item_ready);
  assign byte_en  = in_valid && in_ready;

  dlt_opdecode #(.KEY_LEN(KEY_LEN)) u_dec (
    .opc_byte (in_data),
    .plan     (plan),
    .addr_len (dec_alen),
    .data_len (dec_dlen)
  );

  dlt_item_asm #(.ITEM_W(ITEM_W)) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (brk),
    .en      (asm_en),
    .byte_in (in_data),
    .len     (cur_len),
    .last    (item_last),
    .value   (item_value)
  );

  dlt_seq #(.ITEM_W(ITEM_W), .REP_W(REP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk        (brk),
    .byte_en    (byte_en),
    .plan_in    (plan),
    .item_last  (item_last),
    .item_value (item_value),
    .asm_en     (asm_en),
    .cur_len    (cur_len),
    .item_fire  (item_fire),
    .item_rd    (item_rd),
    .opc_take   (opc_take),
    .done       (insn_done),
    .busy       (busy),
    .rep_count  (rep_count)
  );

  // Output item register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      item_valid   <= 1'b0;
      item_data    <= '0;
      item_is_read <= 1'b0;
      item_len     <= '0;
    end else if (item_fire) begin
      item_valid   <= 1'b1;
      item_data    <= item_value;
      item_is_read <= item_rd;
      item_len     <= cur_len;
    end else if (item_ready) begin
      item_valid <= 1'b0;
    end
  end

  // Opcode field latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_strobe   <= 1'b0;
      op_code     <= '0;
      op_addr_len <= '0;
      op_data_len <= '0;
      op_sel      <= '0;
    end else begin
      op_strobe <= opc_take;
      if (opc_take) begin
        op_code     <= in_data[7:5];
        op_addr_len <= dec_alen;
        op_data_len <= dec_dlen;
        op_sel      <= in_data[3:0];
      end
    end
  end

  // R8: a stalled item is held unchanged
  a_r8_item_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (item_valid && !item_ready) |=>
      (item_valid && $stable(item_data) && $stable(item_is_read) && $stable(item_len)))
    else $error("stalled item changed");

  // R7: completion coincides with a presented item
  a_r7_done_with_item: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done |-> item_valid)
    else $error("done without item");

  // R6: no byte is taken during a break
  a_r6_no_take_in_break: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !in_ready)
    else $error("byte accepted during break");

  // R1: opcode strobe lasts one cycle
  a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    op_strobe |=> !op_strobe)
    else $error("opcode strobe longer than one cycle");

endmodule

// File: tb/sim_dlt_insn_tracker.sv
module sim_dlt_insn_tracker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        brk = 1'b0;
  logic        item_valid;
  logic        item_ready = 1'b1;
  logic [31:0] item_data;
  logic        item_is_read;
  logic [3:0]  item_len;
  logic        op_strobe;
  logic [2:0]  op_code;
  logic [2:0]  op_addr_len;
  logic [2:0]  op_data_len;
  logic [3:0]  op_sel;
  logic        busy;
  logic        insn_done;
  logic [31:0] rep_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  dlt_insn_tracker u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .brk(brk), .item_valid(item_valid),
    .item_ready(item_ready), .item_data(item_data), .item_is_read(item_is_read),
    .item_len(item_len), .op_strobe(op_strobe), .op_code(op_code),
    .op_addr_len(op_addr_len), .op_data_len(op_data_len), .op_sel(op_sel),
    .busy(busy), .insn_done(insn_done), .rep_count(rep_count)
  );

  int checks = 0;
  int errors = 0;
  int got_n, done_n, strobe_n, done_at, exp_n, stream_n, cyc;
  logic [31:0] got_val [64];
  logic        got_rd  [64];
  logic [3:0]  got_len [64];
  logic [31:0] exp_val [64];
  logic        exp_rd  [64];
  int          exp_len [64];
  logic [7:0]  stream  [64];
  logic [31:0] model_rep = 32'd0;
  bit          bp_mode = 1'b0;
  bit          prev_stall = 1'b0;
  logic [31:0] pv_data;
  logic        pv_rd;
  logic [3:0]  pv_len;

  task automatic check_eq(input string req, input string what,
                          input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int seed, input int p);
    return 8'((seed * 37 + p * 13 + 5) & 255);
  endfunction

  // consumer ready pattern
  initial begin
    cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      item_ready = bp_mode ? ((cyc % 3) == 0) : 1'b1;
    end
  end

  // output monitor, sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (insn_done) begin done_n++; done_at = got_n; end
      if (op_strobe) strobe_n++;
      if (rst_n) begin
        if (prev_stall) begin
          checks++;
          if (!(item_valid && item_data == pv_data && item_is_read == pv_rd
                && item_len == pv_len)) begin
            errors++;
            $display("FAIL R8 stalled item changed: actual %0h expected %0h",
                     item_data, pv_data);
          end
        end
        if (item_valid && !item_ready) begin
          checks++;
          if (in_ready) begin
            errors++;
            $display("FAIL R8 in_ready while stalled: actual 1 expected 0");
          end
        end
      end
      prev_stall = item_valid && !item_ready;
      pv_data = item_data; pv_rd = item_is_read; pv_len = item_len;
      if (item_valid && item_ready) begin
        if (got_n < 64) begin
          got_val[got_n] = item_data;
          got_rd[got_n]  = item_is_read;
          got_len[got_n] = item_len;
        end
        got_n++;
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic add_item(input int len, input logic rd, input int seed);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] bb;
      bb = gen(seed, stream_n);
      stream[stream_n] = bb;
      if (i < 4) v[8*i +: 8] = bb;
      stream_n++;
    end
    exp_len[exp_n] = len;
    exp_rd[exp_n]  = rd;
    exp_val[exp_n] = v;
    exp_n++;
  endtask

  // expected item list from the opcode layout rules (R2..R5)
  task automatic build(input logic [7:0] opb, input int seed);
    int a, d;
    a = int'(opb[3:2]) + 1;
    d = int'(opb[1:0]) + 1;
    stream_n = 0;
    exp_n = 0;
    case (opb[7:5])
      3'd0: begin add_item(a, 1'b0, seed); add_item(d, 1'b1, seed); end
      3'd1: for (int k = 0; k <= int'(model_rep); k++) add_item(d, 1'b1, seed);
      3'd2: begin add_item(a, 1'b0, seed); add_item(d, 1'b0, seed); end
      3'd3: for (int k = 0; k <= int'(model_rep); k++) add_item(d, 1'b0, seed);
      3'd4: add_item(1, 1'b1, seed);
      3'd5: add_item(d, 1'b0, seed);
      3'd6: add_item(1, 1'b0, seed);
      default: add_item(8, 1'b0, seed);
    endcase
    if (opb[7:5] == 3'd1 || opb[7:5] == 3'd3) model_rep = 32'd0;
    if (opb[7:5] == 3'd5) model_rep = exp_val[0];
  endtask

  task automatic exec(input logic [7:0] opb);
    got_n = 0; done_n = 0; strobe_n = 0; done_at = -1;
    send(opb);
    for (int i = 0; i < stream_n; i++) send(stream[i]);
    repeat (3) @(negedge clk);
    while (item_valid) @(negedge clk);
    @(negedge clk);
    check_eq("R2", $sformatf("item count op %0h", opb), got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n && i < 64; i++) begin
      check_eq("R2", $sformatf("len op %0h item %0d", opb, i), got_len[i], exp_len[i]);
      check_eq("R3", $sformatf("dir op %0h item %0d", opb, i), got_rd[i], exp_rd[i]);
      check_eq("R4", $sformatf("value op %0h item %0d", opb, i), got_val[i], exp_val[i]);
    end
    check_eq("R7", "done pulses", done_n, 1);
    check_eq("R7", "done at last item", done_at, exp_n - 1);
    check_eq("R1", "strobe pulses", strobe_n, 1);
    check_eq("R1", "op_code", op_code, opb[7:5]);
    check_eq("R1", "op_addr_len", op_addr_len, int'(opb[3:2]) + 1);
    check_eq("R1", "op_data_len", op_data_len, int'(opb[1:0]) + 1);
    check_eq("R1", "op_sel", op_sel, opb[3:0]);
    check_eq("R5", "rep_count", rep_count, model_rep);
    check_eq("R6", "idle after instruction", busy, 0);
  endtask

  task automatic run_insn(input logic [7:0] opb, input int seed);
    build(opb, seed);
    exec(opb);
  endtask

  // count instruction with explicit value n over nb bytes
  task automatic run_repeat(input int n, input int nb);
    stream_n = 0;
    exp_n = 1;
    for (int i = 0; i < nb; i++) stream[stream_n++] = 8'((n >> (8*i)) & 255);
    exp_len[0] = nb; exp_rd[0] = 1'b0; exp_val[0] = 32'(n);
    model_rep = 32'(n);
    exec(8'hA0 | 8'(nb - 1));
  endtask

  task automatic pulse_brk;
    @(posedge clk); #1;
    brk = 1'b1;
    in_valid = 1'b1;
    in_data = 8'h55;
    @(negedge clk);
    check_eq("R6", "in_ready during break", in_ready, 0);
    @(posedge clk); #1;
    brk = 1'b0;
    in_valid = 1'b0;
    model_rep = 32'd0;
    @(negedge clk);
    check_eq("R6", "busy after break", busy, 0);
    check_eq("R6", "rep_count after break", rep_count, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_eq("R9", "item_valid", item_valid, 0);
    check_eq("R9", "insn_done", insn_done, 0);
    check_eq("R9", "op_strobe", op_strobe, 0);
    check_eq("R9", "busy", busy, 0);
    check_eq("R9", "rep_count", rep_count, 0);
    check_eq("R9", "in_ready", in_ready, 1);

    // full opcode sweep (R1..R5, R7)
    for (int b = 0; b < 256; b++) run_insn(8'(b), b);

    pulse_brk();

    // repeat counts applied to pointer loads and stores (R5)
    for (int n = 0; n < 4; n++) begin
      run_repeat(n, 1 + (n % 2));
      run_insn(8'h20 | 8'(n), 40 + n);
      run_repeat(n, 1);
      run_insn(8'h64 | 8'(3 - n), 50 + n);
    end
    // count survives an unrelated instruction (R5)
    run_repeat(2, 1);
    run_insn(8'hC1, 7);
    run_insn(8'h02, 8);
    run_insn(8'h21, 9);

    // break mid-instruction drops partial item and count (R6)
    run_repeat(3, 1);
    got_n = 0;
    send(8'h0F);
    send(8'h11);
    pulse_brk();
    repeat (2) @(negedge clk);
    check_eq("R6", "no item from aborted instruction", got_n, 0);
    run_insn(8'h22, 11);
    run_insn(8'h61, 12);

    // back-pressure pass (R8)
    bp_mode = 1'b1;
    for (int b = 0; b < 256; b += 7) begin
      if (b[7:5] == 3'd5) continue;
      run_insn(8'(b), b + 3);
    end
    run_insn(8'hE0, 99);
    run_repeat(2, 2);
    run_insn(8'h73, 21);
    bp_mode = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule